// File: doc/BRIEF.md
# Endpoint Type-0 Configuration Register File

This block is the configuration register file of a PCIe endpoint function. Configuration accesses from the transaction layer reach it as doubleword reads and writes. Each access carries a byte offset in a 4 KB space and four byte-enable bits. Read data comes back one cycle after the request. A write takes effect at the clock edge that samples it and gives no response.

The file holds the following registers:
- the identification words;
- the command and status pair;
- six base address registers that answer a size probe;
- a capability pointer;
- the interrupt line and pin bytes.

Legacy-only fields read as zero. So do all unimplemented offsets and the whole extended region.

The transaction logic signals events to the block with single-cycle pulses: completions received with error status, aborts signalled, error messages sent and poisoned packets seen. Each pulse sets a sticky status bit, which software clears by writing one to it. The enable bits of the command register are driven out to the rest of the function, together with a legacy interrupt request that the interrupt-disable bit gates.

Top module: `ep_cfg_regfile`

## Requirements
- R1: A read request (`req_valid`=1, `req_write`=0) gives `rd_valid`=1 with `rd_data` in the next cycle. `rd_valid` is 0 in every cycle that does not follow a read request. Byte offset bits [1:0] are ignored.
- R2: Word 00h reads {DEVICE_ID, VENDOR_ID} and word 08h reads CLASS_REV. Word 0Ch reads zero, so the header-type byte is 00h. Writes to these words have no effect.
- R3: Command register (word 04h, bits [15:0]): bit 0 I/O enable, bit 1 memory enable, bit 2 bus master enable, bit 6 parity error response, bit 8 SERR enable and bit 10 interrupt disable are read/write and reset to 0. Every other command bit reads 0. The outputs `io_space_en`, `mem_space_en`, `bus_master_en`, `parity_resp_en`, `serr_en` and `intx_disable` follow bits 0, 1, 2, 6, 8 and 10.
- R4: Status register (word 04h, bits [31:16], status bit n at word bit 16+n). Each event pulse sets one bit at the next edge:
  - `ev_poison_rcvd` sets bit 15;
  - `ev_err_msg_sent` sets bit 14;
  - `ev_ur_cpl_rcvd` sets bit 13;
  - `ev_ca_cpl_rcvd` sets bit 12;
  - `ev_ca_cpl_sent` sets bit 11.
- R5: Status bit 8 is set by `ev_poison_master` only while command bit 6 is 1. The same pulse with bit 6 at 0 leaves it unchanged.
- R6: Status bits 8, 11 to 15 clear when software writes one to them with byte enable 3 set. They hold when software writes zero. An event in the same cycle as the clear wins.
- R7: Status bit 4 reads 1 and status bit 3 reads `intx_pending`. Word 34h reads CAP_PTR in bits [7:0]. `intx_assert` equals `intx_pending` while command bit 10 is 0 and is 0 while bit 10 is 1.
- R8: After all ones are written, a used base address register (words 10h to 24h) reads ones in its address bits and zeros below its region size. Bit 0 reads 0 (memory), bits [2:1] read 00 for 32-bit and 10 for 64-bit, and bit 3 reads the prefetch flag. Defaults are BAR0 4 KB, BAR2/3 a 64-bit prefetchable 1 MB pair and BAR4 128 B. With defaults, an all-ones write reads back FFFFF000h from BAR0, FFF0000Ch from BAR2 and FFFFFF80h from BAR4.
- R9: An unused base address register (BAR1, BAR5 by default) reads 00000000h even after an all-ones write.
- R10: The upper half of a 64-bit pair (BAR3) has all 32 bits read/write and reads FFFFFFFFh after an all-ones write.
- R11: Word 3Ch bits [7:0] (interrupt line) are read/write, bits [15:8] read INT_PIN, and bits [31:16] (offsets 3Eh, 3Fh) read 00h.
- R12: Unimplemented words in 000h to 0FFh and every offset from 100h to FFFh read 0, and writes to them have no effect.
- R13: A write changes only the bytes whose `req_be` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 12 | Byte offset within the space |
| req_be | input | 4 | Byte enables of the write |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| ev_poison_rcvd | input | 1 | Poisoned packet received |
| ev_err_msg_sent | input | 1 | Fatal or non-fatal error message sent |
| ev_ur_cpl_rcvd | input | 1 | Unsupported-request completion received |
| ev_ca_cpl_rcvd | input | 1 | Completer-abort completion received |
| ev_ca_cpl_sent | input | 1 | Request completed with completer abort |
| ev_poison_master | input | 1 | Poisoned data seen as requester |
| intx_pending | input | 1 | Legacy interrupt pending in the function |
| io_space_en | output | 1 | I/O decode enable |
| mem_space_en | output | 1 | Memory decode enable |
| bus_master_en | output | 1 | Permission to issue memory and I/O requests |
| parity_resp_en | output | 1 | Parity error response enable |
| serr_en | output | 1 | Fatal and non-fatal error reporting enable |
| intx_disable | output | 1 | Legacy interrupt disable |
| intx_assert | output | 1 | Gated legacy interrupt request |

## Verification
The hardest situation to reach from the ports is an event pulse landing in the same cycle as a write-one-to-clear of the bit it sets. A separate ordering of the two would pass, so only exact alignment shows which one wins. A directed task drives the clearing write and the event at the same falling edge, then reads the status back.

The master parity bit is also hard to reach, because its outcome depends on the command register. The stimulus pulses its event with parity response both off and on. The random phase mixes command writes, clears, probes and events so that these orderings recur.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;

   localparam int unsigned BAR_NONE = 0;
   localparam int unsigned BAR_M32  = 1;
   localparam int unsigned BAR_M64L = 2;
   localparam int unsigned BAR_M64H = 3;

   localparam int unsigned WORD_ID     = 0;
   localparam int unsigned WORD_CMDSTS = 1;
   localparam int unsigned WORD_CLASS  = 2;
   localparam int unsigned WORD_BAR0   = 4;
   localparam int unsigned WORD_CAP    = 13;
   localparam int unsigned WORD_INTR   = 15;

   localparam logic [15:0] CMD_WMASK    = 16'h0547;
   localparam logic [15:0] STS_W1C_MASK = 16'hF900;

   localparam int unsigned MIN_BAR_LOG2 = 7;

   function automatic logic [31:0] be_to_mask(input logic [3:0] be);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
      return m;
   endfunction

   function automatic logic [31:0] masked_merge(input logic [31:0] old_v,
                                                input logic [31:0] new_v,
                                                input logic [31:0] keep_m);
      return (old_v & ~keep_m) | (new_v & keep_m);
   endfunction

endpackage

// File: rtl/ep_cfg_bar.sv
module ep_cfg_bar
   import ep_cfg_pkg::*;
#(
   parameter int unsigned KIND = BAR_M32,
   parameter int unsigned LOG2 = 12,
   parameter bit          PREF = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [3:0]  be,
   input  logic [31:0] wdata,
   output logic [31:0] rdata
);

   localparam logic [31:0] SIZE_MASK  = ~((32'd1 << LOG2) - 32'd1);
   localparam logic [31:0] ADDR_MASK  = (KIND == BAR_M64H) ? 32'hFFFF_FFFF : SIZE_MASK;
   localparam logic [1:0]  WIDTH_CODE = (KIND == BAR_M64L) ? 2'b10 : 2'b00;
   localparam logic [31:0] TYPE_BITS  = (KIND == BAR_M64H) ? 32'h0
                                      : {28'h0, PREF, WIDTH_CODE, 1'b0};

   generate
      if (KIND == BAR_NONE) begin : g_unused
         wire unused_bar_inputs = ^{clk, rst_n, wr_en, be, wdata};
         assign rdata = 32'h0;
      end else begin : g_used
         logic [31:0] base_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               base_q <= 32'h0;
            end else if (wr_en) begin
               base_q <= masked_merge(base_q, wdata, be_to_mask(be) & ADDR_MASK);
            end
         end
         assign rdata = (base_q & ADDR_MASK) | TYPE_BITS;
      end
   endgenerate

endmodule

// File: rtl/ep_cfg_cmd.sv
module ep_cfg_cmd
   import ep_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  be,
   input  logic [15:0] wdata,
   output logic [15:0] cmd_o
);

   logic [15:0] cmd_q;
   logic [15:0] keep;

   assign keep = {{8{be[1]}}, {8{be[0]}}} & CMD_WMASK;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q <= 16'h0;
      end else if (wr_en) begin
         cmd_q <= (cmd_q & ~keep) | (wdata & keep);
      end
   end

   assign cmd_o = cmd_q & CMD_WMASK;

endmodule

// File: rtl/ep_cfg_status.sv
module ep_cfg_status
   import ep_cfg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clr_en,
   input  logic [7:0]  clr_hi,
   input  logic        per_en,
   input  logic        ev_poison_rcvd,
   input  logic        ev_err_msg_sent,
   input  logic        ev_ur_cpl_rcvd,
   input  logic        ev_ca_cpl_rcvd,
   input  logic        ev_ca_cpl_sent,
   input  logic        ev_poison_master,
   input  logic        intx_pending,
   output logic [15:0] status_o
);

   logic [15:0] sticky_q;
   logic [15:0] set_v;
   logic [15:0] clr_v;

   always_comb begin
      set_v     = 16'h0;
      set_v[15] = ev_poison_rcvd;
      set_v[14] = ev_err_msg_sent;
      set_v[13] = ev_ur_cpl_rcvd;
      set_v[12] = ev_ca_cpl_rcvd;
      set_v[11] = ev_ca_cpl_sent;
      set_v[8]  = ev_poison_master & per_en;
      clr_v     = clr_en ? ({clr_hi, 8'h00} & STS_W1C_MASK) : 16'h0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_q <= 16'h0;
      end else begin
         sticky_q <= ((sticky_q & ~clr_v) | set_v) & STS_W1C_MASK;
      end
   end

   always_comb begin
      status_o    = sticky_q;
      status_o[4] = 1'b1;
      status_o[3] = intx_pending;
   end

endmodule

// File: rtl/ep_cfg_regfile.sv
module ep_cfg_regfile
   import ep_cfg_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID = 16'hABCD,
   parameter logic [15:0] DEVICE_ID = 16'h0123,
   parameter logic [31:0] CLASS_REV = 32'h0580_0001,
   parameter logic [7:0]  CAP_PTR   = 8'h40,
   parameter logic [7:0]  INT_PIN   = 8'h01,
   parameter int unsigned NUM_BAR   = 6,
   parameter logic [2*NUM_BAR-1:0] BAR_KINDS = {2'd0, 2'd1, 2'd3, 2'd2, 2'd0, 2'd1},
   parameter logic [6*NUM_BAR-1:0] BAR_LOG2S = {6'd0, 6'd7, 6'd0, 6'd20, 6'd0, 6'd12},
   parameter logic [NUM_BAR-1:0]   BAR_PREF  = 6'b000100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic [11:0] req_addr,
   input  logic [3:0]  req_be,
   input  logic [31:0] req_wdata,
   output logic        rd_valid,
   output logic [31:0] rd_data,
   input  logic        ev_poison_rcvd,
   input  logic        ev_err_msg_sent,
   input  logic        ev_ur_cpl_rcvd,
   input  logic        ev_ca_cpl_rcvd,
   input  logic        ev_ca_cpl_sent,
   input  logic        ev_poison_master,
   input  logic        intx_pending,
   output logic        io_space_en,
   output logic        mem_space_en,
   output logic        bus_master_en,
   output logic        parity_resp_en,
   output logic        serr_en,
   output logic        intx_disable,
   output logic        intx_assert
);

   localparam int unsigned IDX_W = 10;

   if (NUM_BAR != 6) begin : g_bad_count
      $error("type-0 header holds exactly six base address registers");
   end

   logic [IDX_W-1:0] idx;
   logic             wr_any;
   logic [15:0]      cmd_q;
   logic [15:0]      stat_word;
   logic [7:0]       int_line_q;
   logic [31:0]      bar_rd [NUM_BAR];
   logic [31:0]      rd_next;

   assign idx    = req_addr[11:2];
   assign wr_any = req_valid & req_write;

   wire unused_addr_lsb = ^req_addr[1:0];

   ep_cfg_cmd u_cmd (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_any && idx == IDX_W'(WORD_CMDSTS)),
      .be    (req_be[1:0]),
      .wdata (req_wdata[15:0]),
      .cmd_o (cmd_q)
   );

   ep_cfg_status u_status (
      .clk              (clk),
      .rst_n            (rst_n),
      .clr_en           (wr_any && idx == IDX_W'(WORD_CMDSTS) && req_be[3]),
      .clr_hi           (req_wdata[31:24]),
      .per_en           (cmd_q[6]),
      .ev_poison_rcvd   (ev_poison_rcvd),
      .ev_err_msg_sent  (ev_err_msg_sent),
      .ev_ur_cpl_rcvd   (ev_ur_cpl_rcvd),
      .ev_ca_cpl_rcvd   (ev_ca_cpl_rcvd),
      .ev_ca_cpl_sent   (ev_ca_cpl_sent),
      .ev_poison_master (ev_poison_master),
      .intx_pending     (intx_pending),
      .status_o         (stat_word)
   );

   for (genvar i = 0; i < NUM_BAR; i++) begin : g_bar
      localparam int unsigned KIND = int'(BAR_KINDS[2*i +: 2]);
      localparam int unsigned LOG2 = int'(BAR_LOG2S[6*i +: 6]);

      if ((KIND == BAR_M32 || KIND == BAR_M64L) &&
          (LOG2 < MIN_BAR_LOG2 || LOG2 > 31)) begin : g_bad_size
         $error("base address region size out of range");
      end
      if (KIND == BAR_M64L && i == NUM_BAR - 1) begin : g_bad_last
         $error("64-bit pair cannot start at the last slot");
      end
      if (KIND == BAR_M64L && i < NUM_BAR - 1) begin : g_chk_pair
         if (int'(BAR_KINDS[2*(i+1) +: 2]) != BAR_M64H) begin : g_bad_pair
            $error("64-bit lower half must be followed by an upper half");
         end
      end
      if (KIND == BAR_M64H && i == 0) begin : g_bad_first
         $error("upper half cannot be the first slot");
      end

      ep_cfg_bar #(
         .KIND (KIND),
         .LOG2 (LOG2),
         .PREF (BAR_PREF[i])
      ) u_bar (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (wr_any && idx == IDX_W'(WORD_BAR0 + i)),
         .be    (req_be),
         .wdata (req_wdata),
         .rdata (bar_rd[i])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         int_line_q <= 8'h0;
      end else if (wr_any && idx == IDX_W'(WORD_INTR) && req_be[0]) begin
         int_line_q <= req_wdata[7:0];
      end
   end

   always_comb begin
      rd_next = 32'h0;
      case (idx)
         IDX_W'(WORD_ID):     rd_next = {DEVICE_ID, VENDOR_ID};
         IDX_W'(WORD_CMDSTS): rd_next = {stat_word, cmd_q};
         IDX_W'(WORD_CLASS):  rd_next = CLASS_REV;
         IDX_W'(WORD_CAP):    rd_next = {24'h0, CAP_PTR};
         IDX_W'(WORD_INTR):   rd_next = {16'h0, INT_PIN, int_line_q};
         default:             rd_next = 32'h0;
      endcase
      for (int i = 0; i < NUM_BAR; i++) begin
         if (idx == IDX_W'(WORD_BAR0 + i)) rd_next = bar_rd[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 32'h0;
      end else begin
         rd_valid <= req_valid & ~req_write;
         if (req_valid && !req_write) rd_data <= rd_next;
      end
   end

   assign io_space_en    = cmd_q[0];
   assign mem_space_en   = cmd_q[1];
   assign bus_master_en  = cmd_q[2];
   assign parity_resp_en = cmd_q[6];
   assign serr_en        = cmd_q[8];
   assign intx_disable   = cmd_q[10];
   assign intx_assert    = intx_pending & ~cmd_q[10];

endmodule

// File: rtl/ep_cfg_regfile_chk.sv
module ep_cfg_regfile_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic        req_write,
   input logic [11:0] req_addr,
   input logic [3:0]  req_be,
   input logic        rd_valid,
   input logic [31:0] rd_data,
   input logic        ev_poison_rcvd,
   input logic        ev_ur_cpl_rcvd,
   input logic        ev_ca_cpl_sent,
   input logic        ev_poison_master,
   input logic        parity_resp_en,
   input logic        bus_master_en,
   input logic [15:0] stat_word
);

   a_r1_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && !req_write) |=> !rd_valid);

   a_r4_poison_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_poison_rcvd |=> stat_word[15]);

   a_r4_ur_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ur_cpl_rcvd |=> stat_word[13]);

   a_r6_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ev_ca_cpl_sent |=> stat_word[11]);

   a_r5_mdpe_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_word[8] && !(ev_poison_master && parity_resp_en)) |=> !stat_word[8]);

   a_r3_bme_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write && req_addr[11:2] == 10'd1 && req_be[0])
      |=> $stable(bus_master_en));

   a_r11_hardwired: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(req_addr[11:2]) == 10'd15) |-> rd_data[31:16] == 16'h0);

   a_r12_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(req_addr[11:8]) != 4'h0) |-> rd_data == 32'h0);

endmodule

bind ep_cfg_regfile ep_cfg_regfile_chk u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .req_valid        (req_valid),
   .req_write        (req_write),
   .req_addr         (req_addr),
   .req_be           (req_be),
   .rd_valid         (rd_valid),
   .rd_data          (rd_data),
   .ev_poison_rcvd   (ev_poison_rcvd),
   .ev_ur_cpl_rcvd   (ev_ur_cpl_rcvd),
   .ev_ca_cpl_sent   (ev_ca_cpl_sent),
   .ev_poison_master (ev_poison_master),
   .parity_resp_en   (parity_resp_en),
   .bus_master_en    (bus_master_en),
   .stat_word        (stat_word)
);

// File: tb/ep_cfg_regfile_test.sv
module ep_cfg_regfile_test;

   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [11:0] req_addr = '0;
   logic [3:0]  req_be = '0;
   logic [31:0] req_wdata = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic [5:0]  ev = '0;
   logic        intx_pending = 1'b0;
   logic        io_space_en, mem_space_en, bus_master_en, parity_resp_en;
   logic        serr_en, intx_disable, intx_assert;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   logic [15:0] m_cmd, m_sticky;
   logic [31:0] m_bar [6];
   logic [7:0]  m_line;

   always #(CLK_PERIOD/2) clk = ~clk;

   ep_cfg_regfile uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .ev_poison_rcvd(ev[0]), .ev_ur_cpl_rcvd(ev[1]), .ev_ca_cpl_rcvd(ev[2]),
      .ev_ca_cpl_sent(ev[3]), .ev_err_msg_sent(ev[4]), .ev_poison_master(ev[5]),
      .intx_pending(intx_pending),
      .io_space_en(io_space_en), .mem_space_en(mem_space_en),
      .bus_master_en(bus_master_en), .parity_resp_en(parity_resp_en),
      .serr_en(serr_en), .intx_disable(intx_disable), .intx_assert(intx_assert)
   );

   function automatic logic [31:0] bar_wmask(input int i);
      case (i)
         0: return 32'hFFFF_F000;
         2: return 32'hFFF0_0000;
         3: return 32'hFFFF_FFFF;
         4: return 32'hFFFF_FF80;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] bar_type(input int i);
      return (i == 2) ? 32'h0000_000C : 32'h0;
   endfunction

   function automatic logic [31:0] bmask(input logic [3:0] be);
      return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      int idx = int'(a[11:2]);
      case (idx)
         0:  return 32'h0123_ABCD;
         1:  return {m_sticky | {12'h0, intx_pending, 3'b000} | 16'h0010, m_cmd};
         2:  return 32'h0580_0001;
         13: return 32'h0000_0040;
         15: return {16'h0, 8'h01, m_line};
         default: begin
            if (idx >= 4 && idx <= 9) return m_bar[idx-4] | bar_type(idx-4);
            return 32'h0;
         end
      endcase
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      int idx = int'(a[11:2]);
      if (idx == 0 || idx == 2 || idx == 3) return "R2";
      if (idx == 1) return "R4";
      if (idx >= 4 && idx <= 9) return "R8";
      if (idx == 13) return "R7";
      if (idx == 15) return "R11";
      return "R12";
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      int idx = int'(a[11:2]);
      logic [31:0] bm = bmask(be);
      if (idx == 1) begin
         m_cmd = (m_cmd & ~(bm[15:0] & 16'h0547)) | (d[15:0] & bm[15:0] & 16'h0547);
         if (be[3]) m_sticky = m_sticky & ~({d[31:24], 8'h00} & 16'hF900);
      end else if (idx >= 4 && idx <= 9) begin
         m_bar[idx-4] = (m_bar[idx-4] & ~(bm & bar_wmask(idx-4))) | (d & bm & bar_wmask(idx-4));
      end else if (idx == 15 && be[0]) begin
         m_line = d[7:0];
      end
   endtask

   task automatic model_event(input logic [5:0] e);
      if (e[0]) m_sticky[15] = 1'b1;
      if (e[1]) m_sticky[13] = 1'b1;
      if (e[2]) m_sticky[12] = 1'b1;
      if (e[3]) m_sticky[11] = 1'b1;
      if (e[4]) m_sticky[14] = 1'b1;
      if (e[5] && m_cmd[6]) m_sticky[8] = 1'b1;
   endtask

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
      @(posedge clk);
      model_write(a, d, be);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check("R1", {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic cfg_rd(input logic [11:0] a, input string req);
      logic [31:0] e;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      e = exp_read(a);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      check("R1", {31'h0, rd_valid}, 32'h1);
      check(req, rd_data, e);
   endtask

   task automatic pulse(input logic [5:0] e);
      @(negedge clk);
      ev = e;
      @(posedge clk);
      model_event(e);
      @(negedge clk);
      ev = '0;
   endtask

   task automatic check_outputs();
      check("R3", {26'h0, io_space_en, mem_space_en, bus_master_en, parity_resp_en,
                   serr_en, intx_disable},
            {26'h0, m_cmd[0], m_cmd[1], m_cmd[2], m_cmd[6], m_cmd[8], m_cmd[10]});
      check("R7", {31'h0, intx_assert}, {31'h0, intx_pending & ~m_cmd[10]});
   endtask

   function automatic logic [11:0] pick_addr(input int k);
      case (k % 15)
         0:  return 12'h000;  1: return 12'h004;  2: return 12'h008;
         3:  return 12'h00C;  4: return 12'h010;  5: return 12'h014;
         6:  return 12'h018;  7: return 12'h01C;  8: return 12'h020;
         9:  return 12'h024; 10: return 12'h034; 11: return 12'h03C;
         12: return 12'h040; 13: return 12'h100;
         default: return 12'hFFC;
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd2024));
      m_cmd = '0; m_sticky = '0; m_line = '0;
      for (int i = 0; i < 6; i++) m_bar[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // reset state
      check("R1", {31'h0, rd_valid}, 32'h0);
      check_outputs();
      cfg_rd(12'h000, "R2");
      cfg_rd(12'h004, "R4");
      cfg_rd(12'h018, "R8");

      // identification is read-only; byte offset low bits ignored (R1)
      cfg_wr(12'h000, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(12'h002, "R2");
      cfg_wr(12'h00C, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(12'h00C, "R2");

      // size probe: R8 R9 R10
      for (int i = 0; i < 6; i++) cfg_wr(12'h010 + 12'(4*i), 32'hFFFF_FFFF, 4'hF);
      cfg_rd(12'h010, "R8");  check("R8", rd_data, 32'hFFFF_F000);
      cfg_rd(12'h014, "R9");  check("R9", rd_data, 32'h0);
      cfg_rd(12'h018, "R8");  check("R8", rd_data, 32'hFFF0_000C);
      cfg_rd(12'h01C, "R10"); check("R10", rd_data, 32'hFFFF_FFFF);
      cfg_rd(12'h020, "R8");  check("R8", rd_data, 32'hFFFF_FF80);
      cfg_rd(12'h024, "R9");  check("R9", rd_data, 32'h0);

      // byte enables on a base register (R13)
      cfg_wr(12'h010, 32'h1234_5678, 4'b0100);
      cfg_rd(12'h010, "R13"); check("R13", rd_data, 32'hFF34_F000);

      // command register (R3, R13)
      cfg_wr(12'h004, 32'h0000_FFFF, 4'b0001);
      cfg_rd(12'h004, "R13"); check_outputs();
      cfg_wr(12'h004, 32'h0000_FFFF, 4'b0011);
      cfg_rd(12'h004, "R3"); check("R3", {16'h0, rd_data[15:0]}, 32'h0000_0547);
      check_outputs();

      // interrupt status and gating (R7)
      intx_pending = 1'b1;
      cfg_rd(12'h004, "R7"); check_outputs();
      cfg_wr(12'h004, 32'h0000_0000, 4'b0010);
      cfg_rd(12'h034, "R7"); check_outputs();

      // master data parity gated by command bit 6 (R5)
      cfg_wr(12'h004, 32'h0000_0000, 4'b0001);
      pulse(6'b100000);
      cfg_rd(12'h004, "R5"); check("R5", {31'h0, rd_data[24]}, 32'h0);
      cfg_wr(12'h004, 32'h0000_0040, 4'b0001);
      pulse(6'b100000);
      cfg_rd(12'h004, "R5"); check("R5", {31'h0, rd_data[24]}, 32'h1);

      // each event sets its bit (R4)
      for (int b = 0; b < 5; b++) begin
         pulse(6'(1 << b));
         cfg_rd(12'h004, "R4");
      end

      // write one to clear; zero holds (R6)
      cfg_wr(12'h004, 32'h0000_0000, 4'b1000);
      cfg_rd(12'h004, "R6");
      cfg_wr(12'h004, 32'hF900_0000, 4'b1000);
      cfg_rd(12'h004, "R6"); check("R6", {16'h0, rd_data[31:16]}, {16'h0, 16'h0018});

      // event in the same cycle as its clear wins (R6)
      pulse(6'b000001);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h004;
      req_wdata = 32'h8000_0000; req_be = 4'b1000; ev = 6'b000001;
      @(posedge clk);
      model_write(12'h004, 32'h8000_0000, 4'b1000);
      model_event(6'b000001);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; ev = '0;
      cfg_rd(12'h004, "R6"); check("R6", {31'h0, rd_data[31]}, 32'h1);

      // interrupt line and hardwired bytes (R11)
      cfg_wr(12'h03C, 32'hFFFF_FF5A, 4'hF);
      cfg_rd(12'h03C, "R11"); check("R11", rd_data, 32'h0000_015A);

      // unimplemented and extended space (R12)
      cfg_wr(12'h100, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(12'h100, "R12");
      cfg_wr(12'hFFC, 32'hFFFF_FFFF, 4'hF);
      cfg_rd(12'hFFC, "R12");
      cfg_rd(12'h040, "R12");

      // constrained random mix
      for (int n = 0; n < 600; n++) begin
         int op = int'($urandom % 5);
         logic [11:0] a = pick_addr(int'($urandom % 15));
         if (($urandom % 8) == 0) intx_pending = ~intx_pending;
         case (op)
            0, 1: cfg_wr(a, $urandom, 4'($urandom));
            2, 3: cfg_rd(a, tag_of(a));
            default: pulse(6'($urandom));
         endcase
         if (op < 2 && a == 12'h004) check_outputs();
      end
      check_outputs();

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule